// File: doc/BRIEF.md
# Nibble-Mode Reverse Channel Transmitter

This block sits on the peripheral side of a bidirectional parallel port. It sends bytes back to the host over the four status lines, four bits at a time. Bytes are written into an internal transmit FIFO. Once the reverse mode has been negotiated elsewhere, the engine runs an idle phase and a data transfer phase.

In the idle phase the engine shows on the status lines whether data is waiting, and it raises an interrupt pulse on the printer-clock line. In the transfer phase it presents each nibble and handshakes it with the host through a host-busy input. When the host aborts, or a handshake wait times out, the engine hands the status lines back to their ordinary forward-mode sources.

The negotiation sequence, the other reverse modes and the electrical drivers are handled by neighbouring logic.

Top module: `nibtx_rev`

## Requirements
- R1: After reset, and whenever the engine is in compatibility mode, `rev_active` is 0. In this mode `pclk_line`, `ln_busy`, `ln_paper`, `ln_select` and `ln_fault_n` equal `compat_ack_n`, `fwd_busy`, `compat_paper`, `compat_select` and `compat_fault_n`, respectively.
- R2: A 0-to-1 change of `mode_active` seen by a clock edge moves the engine from compatibility mode into reverse idle at that edge. The register that tracks the previous value resets to 1, so a level that is already high during reset does not count as a rise.
- R3: During the transfer phase the nibble lines are driven as follows. For the first nibble, `ln_fault_n`, `ln_select`, `ln_paper` and `ln_busy` carry byte bits 0, 1, 2 and 3. For the second nibble they carry bits 4, 5, 6 and 7. The low nibble always goes first, and the lines hold steady while `pclk_line` is low.
- R4: Each nibble follows a fixed sequence:
  - the data is presented with `pclk_line` high for `SETTLE_CYC` cycles;
  - `pclk_line` then goes low until `host_busy` is seen high;
  - `pclk_line` then goes high until `host_busy` is seen low.
- R5: In reverse idle and in the interrupt states:
  - `ln_fault_n` is 0 exactly when the FIFO holds data;
  - `ln_busy` shows `fwd_busy`;
  - `ln_select` shows `compat_select`;
  - `ln_paper` is 1 until the first edge at which idle sees `host_busy` low (the request), and from the next cycle on it equals `ln_fault_n`.
- R6: When idle has a request and data is waiting, `pclk_line` goes low (interrupt). A `host_busy` high with `mode_active` high then returns `pclk_line` high. The engine waits for `host_busy` low, takes the FIFO head, and starts its first nibble.
- R7: At the end of the second nibble's handshake, the engine starts the next byte directly if the FIFO is not empty. If the FIFO is empty, it returns to reverse idle.
- R8: In idle or interrupt, `host_busy` high while `mode_active` is low moves the engine to compatibility mode at the next edge. `host_busy` high while `mode_active` is high does not leave idle.
- R9: A handshake wait for `host_busy` that lasts `TIMEOUT_CYC` cycles ends in compatibility mode. A value of 0 disables this timeout. Reverse mode is entered again only on a new rise of `mode_active`.
- R10: The FIFO keeps bytes in write order and holds `FIFO_DEPTH` bytes. `fifo_full` is 1 when it is full. A write is accepted when the FIFO is not full, or when the engine takes the head in the same cycle; otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Byte to be returned to the host |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH bytes |
| mode_active | input | 1 | Negotiated reverse mode is in force |
| host_busy | input | 1 | Host handshake line |
| fwd_busy | input | 1 | Forward-path busy status |
| compat_ack_n | input | 1 | Forward-mode source for the printer-clock line |
| compat_paper | input | 1 | Forward-mode paper-empty status |
| compat_select | input | 1 | Forward-mode online status |
| compat_fault_n | input | 1 | Forward-mode fault status |
| rev_active | output | 1 | Engine is in a reverse phase |
| pclk_line | output | 1 | Printer-clock line (acknowledge line) |
| ln_busy | output | 1 | Busy status line |
| ln_paper | output | 1 | Paper-empty status line |
| ln_select | output | 1 | Select status line |
| ln_fault_n | output | 1 | Fault status line |

## Verification
Two functions can fall in the same cycle: a write arriving while the FIFO is full, and the engine taking the head byte. The bench provokes this by writing on every cycle while the host drains bytes. The per-clock reference model then decides, edge by edge, whether each write lands, and the comparison judges `fifo_full` and the bytes later shown on the lines. The bench also raises `host_busy` and drops `mode_active` in one cycle while the engine is idle, and expects compatibility mode one edge later. Beforehand it checks that the same `host_busy` rise with `mode_active` still high leaves the engine idle.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;

   localparam int BYTE_W = 8;
   localparam int NIB_W  = BYTE_W / 2;

   typedef enum logic [2:0] {
      ST_COMPAT,
      ST_IDLE,
      ST_INTR,
      ST_WLOW,
      ST_SETUP,
      ST_STROBE,
      ST_RELEASE
   } nibtx_state_e;

   typedef struct packed {
      logic busy;
      logic paper;
      logic select;
      logic fault_n;
   } nibtx_lines_t;

endpackage

// File: rtl/nibtx_fifo.sv
module nibtx_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [W-1:0]                 wr_data,
   input  logic                         rd_en,
   output logic [W-1:0]                 rd_data,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("nibtx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          wr_ok, rd_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign count   = cnt_q;
   assign rd_ok   = rd_en && !empty;
   assign wr_ok   = wr_en && (!full || rd_ok);
   assign rd_data = mem[rp_q];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_ok) wp_q <= wp_q + AW'(1);
         if (rd_ok) rp_q <= rp_q + AW'(1);
         cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
      end
   end

endmodule

// File: rtl/nibtx_timer.sv
module nibtx_timer #(
   parameter int SETTLE_CYC  = 2,
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic settle_done,
   output logic expired
);
   localparam int LIMIT = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
   localparam int CW    = $clog2(LIMIT + 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("nibtx_timer: SETTLE_CYC must be at least 1");
      end
      if (TIMEOUT_CYC < 0) begin : g_bad_tmo
         $error("nibtx_timer: TIMEOUT_CYC must not be negative");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (restart)             cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + CW'(1);
   end

   assign settle_done = (cnt_q == CW'(SETTLE_CYC - 1));

   generate
      if (TIMEOUT_CYC == 0) begin : g_no_tmo
         assign expired = 1'b0;
      end else begin : g_tmo
         assign expired = (cnt_q == CW'(TIMEOUT_CYC - 1));
      end
   endgenerate

endmodule

// File: rtl/nibtx_linemap.sv
module nibtx_linemap
   import nibtx_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              hi_sel,
   output nibtx_lines_t      lines
);
   logic [NIB_W-1:0] nib;

   assign nib           = hi_sel ? byte_in[BYTE_W-1:NIB_W] : byte_in[NIB_W-1:0];
   assign lines.fault_n = nib[0];
   assign lines.select  = nib[1];
   assign lines.paper   = nib[2];
   assign lines.busy    = nib[3];

endmodule

// File: rtl/nibtx_rev.sv
module nibtx_rev
   import nibtx_pkg::*;
#(
   parameter int FIFO_DEPTH  = 8,
   parameter int SETTLE_CYC  = 2,
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic       fifo_full,
   input  logic       mode_active,
   input  logic       host_busy,
   input  logic       fwd_busy,
   input  logic       compat_ack_n,
   input  logic       compat_paper,
   input  logic       compat_select,
   input  logic       compat_fault_n,
   output logic       rev_active,
   output logic       pclk_line,
   output logic       ln_busy,
   output logic       ln_paper,
   output logic       ln_select,
   output logic       ln_fault_n
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   nibtx_state_e       st_q, st_d;
   logic               nib_q, nib_d;
   logic [BYTE_W-1:0]  byte_q, fifo_head;
   logic               req_q, mode_q, mode_rise;
   logic               fifo_pop, fifo_empty;
   logic [CNT_W-1:0]   fifo_cnt;
   logic               settle_done, expired;
   nibtx_lines_t       xfer_lines;

   nibtx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (fifo_pop),
      .rd_data (fifo_head),
      .full    (fifo_full),
      .empty   (fifo_empty),
      .count   (fifo_cnt)
   );

   nibtx_timer #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (st_d != st_q),
      .settle_done (settle_done),
      .expired     (expired)
   );

   nibtx_linemap u_map (
      .byte_in (byte_q),
      .hi_sel  (nib_q),
      .lines   (xfer_lines)
   );

   assign mode_rise = mode_active && !mode_q;

   always_comb begin
      st_d     = st_q;
      nib_d    = nib_q;
      fifo_pop = 1'b0;
      case (st_q)
         ST_COMPAT:  if (mode_rise) st_d = ST_IDLE;
         ST_IDLE: begin
            if (host_busy && !mode_active)  st_d = ST_COMPAT;
            else if (req_q && !fifo_empty)  st_d = ST_INTR;
         end
         ST_INTR:    if (host_busy) st_d = mode_active ? ST_WLOW : ST_COMPAT;
         ST_WLOW: begin
            if (!host_busy) begin
               st_d     = ST_SETUP;
               nib_d    = 1'b0;
               fifo_pop = 1'b1;
            end else if (expired) begin
               st_d = ST_COMPAT;
            end
         end
         ST_SETUP:   if (settle_done) st_d = ST_STROBE;
         ST_STROBE: begin
            if (host_busy)     st_d = ST_RELEASE;
            else if (expired)  st_d = ST_COMPAT;
         end
         ST_RELEASE: begin
            if (!host_busy) begin
               if (!nib_q) begin
                  st_d  = ST_SETUP;
                  nib_d = 1'b1;
               end else if (!fifo_empty) begin
                  st_d     = ST_SETUP;
                  nib_d    = 1'b0;
                  fifo_pop = 1'b1;
               end else begin
                  st_d = ST_IDLE;
               end
            end else if (expired) begin
               st_d = ST_COMPAT;
            end
         end
         default:    st_d = ST_COMPAT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_COMPAT;
         nib_q  <= 1'b0;
         byte_q <= '0;
         req_q  <= 1'b0;
         mode_q <= 1'b1;
      end else begin
         st_q   <= st_d;
         nib_q  <= nib_d;
         mode_q <= mode_active;
         if (fifo_pop) byte_q <= fifo_head;
         if (st_d == ST_COMPAT)                 req_q <= 1'b0;
         else if (st_q == ST_IDLE && !host_busy) req_q <= 1'b1;
      end
   end

   always_comb begin
      rev_active = (st_q != ST_COMPAT);
      case (st_q)
         ST_COMPAT: begin
            pclk_line  = compat_ack_n;
            ln_busy    = fwd_busy;
            ln_paper   = compat_paper;
            ln_select  = compat_select;
            ln_fault_n = compat_fault_n;
         end
         ST_IDLE, ST_INTR, ST_WLOW: begin
            pclk_line  = (st_q != ST_INTR);
            ln_busy    = fwd_busy;
            ln_paper   = req_q ? fifo_empty : 1'b1;
            ln_select  = compat_select;
            ln_fault_n = fifo_empty;
         end
         default: begin
            pclk_line  = (st_q != ST_STROBE);
            ln_busy    = xfer_lines.busy;
            ln_paper   = xfer_lines.paper;
            ln_select  = xfer_lines.select;
            ln_fault_n = xfer_lines.fault_n;
         end
      endcase
   end

endmodule

// File: rtl/nibtx_rev_chk.sv
module nibtx_rev_chk
   import nibtx_pkg::*;
#(
   parameter int FIFO_DEPTH = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input nibtx_state_e                   st,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
   input logic                           fifo_pop,
   input logic                           fifo_empty,
   input logic                           host_busy,
   input logic                           mode_active,
   input logic                           fwd_busy,
   input logic                           compat_ack_n,
   input logic                           compat_paper,
   input logic                           compat_select,
   input logic                           compat_fault_n,
   input logic                           rev_active,
   input logic                           pclk_line,
   input logic                           ln_busy,
   input logic                           ln_paper,
   input logic                           ln_select,
   input logic                           ln_fault_n
);

   assert_compat_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rev_active |-> {pclk_line, ln_busy, ln_paper, ln_select, ln_fault_n} ==
                      {compat_ack_n, fwd_busy, compat_paper, compat_select, compat_fault_n});

   assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COMPAT && mode_active && !$past(mode_active)) |=> (st == ST_IDLE));

   assert_lines_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STROBE) |-> $stable({ln_busy, ln_paper, ln_select, ln_fault_n}));

   assert_strobe_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STROBE && host_busy) |=> (st == ST_RELEASE && pclk_line));

   assert_idle_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (ln_fault_n == fifo_empty));

   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE || st == ST_INTR) && host_busy && !mode_active) |=> !rev_active);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

   assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);

endmodule

bind nibtx_rev nibtx_rev_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .st             (st_q),
   .fifo_cnt       (fifo_cnt),
   .fifo_pop       (fifo_pop),
   .fifo_empty     (fifo_empty),
   .host_busy      (host_busy),
   .mode_active    (mode_active),
   .fwd_busy       (fwd_busy),
   .compat_ack_n   (compat_ack_n),
   .compat_paper   (compat_paper),
   .compat_select  (compat_select),
   .compat_fault_n (compat_fault_n),
   .rev_active     (rev_active),
   .pclk_line      (pclk_line),
   .ln_busy        (ln_busy),
   .ln_paper       (ln_paper),
   .ln_select      (ln_select),
   .ln_fault_n     (ln_fault_n)
);

// File: tb/nibtx_rev_test.sv
`timescale 1ns/1ps
module nibtx_rev_test;
   localparam int DEPTH  = 4;
   localparam int SETTLE = 2;
   localparam int TMO    = 8;
   localparam int MAXC   = (SETTLE > TMO) ? SETTLE : TMO;
   localparam int MC = 0, MI = 1, MN = 2, MW = 3, MS = 4, MB = 5, MR = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic man_wr = 1'b0;
   logic [7:0] man_data = 8'h00;
   logic stream_on = 1'b0;
   logic [7:0] stream_data = 8'h80;
   logic mode_active = 1'b0, host_busy = 1'b1, fwd_busy = 1'b0;
   logic compat_ack_n = 1'b1, compat_paper = 1'b0, compat_select = 1'b1, compat_fault_n = 1'b1;
   logic wr_en;
   logic [7:0] wr_data;
   logic fifo_full, rev_active, pclk_line, ln_busy, ln_paper, ln_select, ln_fault_n;

   int checks = 0;
   int fails  = 0;

   assign wr_en   = man_wr | stream_on;
   assign wr_data = stream_on ? stream_data : man_data;

   always #4 clk = ~clk;

   nibtx_rev #(.FIFO_DEPTH(DEPTH), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
      .mode_active(mode_active), .host_busy(host_busy), .fwd_busy(fwd_busy),
      .compat_ack_n(compat_ack_n), .compat_paper(compat_paper),
      .compat_select(compat_select), .compat_fault_n(compat_fault_n),
      .rev_active(rev_active), .pclk_line(pclk_line), .ln_busy(ln_busy),
      .ln_paper(ln_paper), .ln_select(ln_select), .ln_fault_n(ln_fault_n));

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_st = MC, m_cnt = 0, m_nib = 0, m_req = 0, m_prev = 1;
   logic [7:0] m_byte = 8'h00;
   logic [7:0] q[$];

   always @(posedge clk) begin
      int nx, nn, szp;
      bit pop, emp, sd, tm;
      if (!rst_n) begin
         m_st = MC; m_cnt = 0; m_nib = 0; m_req = 0; m_prev = 1; m_byte = 8'h00;
         q.delete();
      end else begin
         szp = q.size(); emp = (szp == 0);
         sd = (m_cnt == SETTLE - 1); tm = (m_cnt == TMO - 1);
         nx = m_st; nn = m_nib; pop = 0;
         case (m_st)
            MC: if (mode_active && !m_prev) nx = MI;
            MI: if (host_busy && !mode_active) nx = MC; else if (m_req != 0 && !emp) nx = MN;
            MN: if (host_busy) nx = mode_active ? MW : MC;
            MW: if (!host_busy) begin nx = MS; nn = 0; pop = 1; end else if (tm) nx = MC;
            MS: if (sd) nx = MB;
            MB: if (host_busy) nx = MR; else if (tm) nx = MC;
            MR: if (!host_busy) begin
                   if (m_nib == 0) begin nx = MS; nn = 1; end
                   else if (!emp) begin nx = MS; nn = 0; pop = 1; end
                   else nx = MI;
                end else if (tm) nx = MC;
            default: nx = MC;
         endcase
         if (nx == MC) m_req = 0;
         else if (m_st == MI && !host_busy) m_req = 1;
         if (pop) m_byte = q.pop_front();
         if (wr_en && (szp < DEPTH || pop)) q.push_back(wr_data);
         m_cnt = (nx != m_st) ? 0 : ((m_cnt < MAXC) ? m_cnt + 1 : m_cnt);
         m_nib = nn; m_st = nx; m_prev = mode_active;
      end
   end

   always @(negedge clk) begin
      logic [5:0] exp_v, act_v;
      logic [3:0] nb;
      bit emp;
      string tag;
      #1;
      if (rst_n) begin
         emp = (q.size() == 0);
         nb = m_nib ? m_byte[7:4] : m_byte[3:0];
         case (m_st)
            MC: begin tag = "R1";
               exp_v = {1'b0, compat_ack_n, fwd_busy, compat_paper, compat_select, compat_fault_n}; end
            MI, MN, MW: begin tag = (m_st == MI) ? "R5" : "R6";
               exp_v = {1'b1, (m_st != MN), fwd_busy, (m_req != 0) ? emp : 1'b1, compat_select, emp}; end
            default: begin tag = (m_st == MS) ? "R3" : "R4";
               exp_v = {1'b1, (m_st != MB), nb[3], nb[2], nb[1], nb[0]}; end
         endcase
         act_v = {rev_active, pclk_line, ln_busy, ln_paper, ln_select, ln_fault_n};
         check(act_v === exp_v, {tag, " per-cycle lines"}, 32'(act_v), 32'(exp_v));
         check(fifo_full === (q.size() == DEPTH), "R10 per-cycle full", 32'(fifo_full), 32'(q.size() == DEPTH));
      end
   end

   // stream writer used to provoke write-while-full with a same-cycle pop
   always @(negedge clk) begin
      #2;
      if (stream_on) stream_data = stream_data + 8'd1;
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk); #2;
   endtask

   task automatic wait_pclk(input logic v);
      for (int n = 0; n < 200 && pclk_line !== v; n++) tick();
   endtask

   task automatic put(input logic [7:0] d);
      man_wr = 1'b1; man_data = d; tick(); man_wr = 1'b0;
   endtask

   task automatic ack_intr();
      wait_pclk(1'b0); host_busy = 1'b1; wait_pclk(1'b1); host_busy = 1'b0;
   endtask

   task automatic read_byte(output logic [7:0] b);
      logic [3:0] nb;
      b = 8'h00;
      for (int k = 0; k < 2; k++) begin
         wait_pclk(1'b0);
         nb = {ln_busy, ln_paper, ln_select, ln_fault_n};
         if (k == 0) b[3:0] = nb; else b[7:4] = nb;
         host_busy = 1'b1; wait_pclk(1'b1); host_busy = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] b;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state and pass-through
      check(rev_active === 1'b0, "R1 reset inactive", 32'(rev_active), 0);
      compat_ack_n = 1'b0; compat_paper = 1'b1; compat_fault_n = 1'b0; fwd_busy = 1'b1; #1;
      check({pclk_line, ln_busy, ln_paper, ln_fault_n} === 4'b0110, "R1 pass-through",
            32'({pclk_line, ln_busy, ln_paper, ln_fault_n}), 32'h6);
      compat_ack_n = 1'b1; compat_paper = 1'b0; compat_fault_n = 1'b1; fwd_busy = 1'b0;
      put(8'hA5); put(8'h3C);
      check(fifo_full === 1'b0, "R10 not full", 32'(fifo_full), 0);
      // R2: entry
      mode_active = 1'b1; tick();
      check(rev_active === 1'b1, "R2 entered idle", 32'(rev_active), 1);
      // R5: idle flags before request
      check(ln_paper === 1'b1 && ln_fault_n === 1'b0, "R5 idle before request",
            32'({ln_paper, ln_fault_n}), 32'h2);
      host_busy = 1'b0; tick();
      check(ln_paper === 1'b0, "R5 paper follows data flag", 32'(ln_paper), 0);
      tick();
      check(pclk_line === 1'b0, "R6 interrupt low", 32'(pclk_line), 0);
      ack_intr();
      read_byte(b); check(b === 8'hA5, "R3 first byte", 32'(b), 32'hA5);
      read_byte(b); check(b === 8'h3C, "R10 second byte order", 32'(b), 32'h3C);
      tick();
      check(rev_active === 1'b1 && pclk_line === 1'b1 && ln_fault_n === 1'b1,
            "R7 back to idle when empty", 32'({rev_active, pclk_line, ln_fault_n}), 32'h7);
      // R7: consecutive bytes without a new interrupt
      put(8'h11); put(8'h22); put(8'h33);
      ack_intr();
      read_byte(b); check(b === 8'h11, "R7 byte 1", 32'(b), 32'h11);
      read_byte(b); check(b === 8'h22, "R7 byte 2", 32'(b), 32'h22);
      read_byte(b); check(b === 8'h33, "R7 byte 3", 32'(b), 32'h33);
      tick();
      // R10: overfill, the fifth write is dropped
      for (int i = 0; i < 5; i++) put(8'h40 + 8'(i));
      check(fifo_full === 1'b1, "R10 full flag", 32'(fifo_full), 1);
      ack_intr();
      for (int i = 0; i < 4; i++) begin
         read_byte(b);
         check(b === 8'h40 + 8'(i), "R10 kept byte", 32'(b), 32'(8'h40 + 8'(i)));
      end
      tick();
      check(ln_fault_n === 1'b1, "R10 dropped write left FIFO empty", 32'(ln_fault_n), 1);
      // same-cycle write and pop under a full FIFO
      stream_on = 1'b1;
      ack_intr();
      for (int i = 0; i < 6; i++) read_byte(b);
      stream_on = 1'b0;
      // R9: host never answers the strobe
      wait_pclk(1'b0);
      repeat (TMO + 2) tick();
      check(rev_active === 1'b0, "R9 timeout to compat", 32'(rev_active), 0);
      repeat (3) tick();
      check(rev_active === 1'b0, "R9 no re-entry while level high", 32'(rev_active), 0);
      host_busy = 1'b1;
      mode_active = 1'b0; tick();
      mode_active = 1'b1; tick();
      check(rev_active === 1'b1, "R2 re-entry on new rise", 32'(rev_active), 1);
      // R8: busy high with mode high stays idle, then abort
      repeat (3) tick();
      check(rev_active === 1'b1 && pclk_line === 1'b1, "R8 no abort with mode high",
            32'({rev_active, pclk_line}), 32'h3);
      mode_active = 1'b0; tick();
      check(rev_active === 1'b0, "R8 abort to compat", 32'(rev_active), 0);
      tick();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule